// File: doc/BRIEF.md
# Integer Execute Unit with HI/LO Multiply-Divide

This block is the integer execute stage of a small load-store RISC core. From an operation code, two register operands and a 16-bit immediate, it produces a single-cycle combinational result for the add, subtract and logical operations. The operations are signed and unsigned add and subtract, add-immediate, AND/OR/XOR in register and immediate forms, register NOR, and load-upper-immediate. The signed add forms also drive an overflow flag. The instruction set has no subtract-immediate: a negative immediate with add-immediate gives the same effect.

Multiply and divide read only the two register sources and write no general register. An issue strobe starts them. They run as a radix-2 iterative sequence, one bit per cycle, and hold `busy` high while they run. They finish with a single write pulse that loads the two special registers. The high register receives the upper product half or the remainder. The low register receives the lower product half or the quotient. The core's issue logic is expected to hold back further multiply or divide issue while `busy` is high.

Top module: `int_exec_unit`

## Requirements
- R1: Operation codes are: add 0, add-unsigned 1, sub 2, sub-unsigned 3, add-imm 4, add-imm-unsigned 5, and 6, or 7, xor 8, nor 9, and-imm 10, or-imm 11, xor-imm 12, load-upper 13, mult 16, mult-unsigned 17, div 18, div-unsigned 19. For codes 0 to 3, `result` is `src_a` plus or minus `src_b`, modulo 2^DATA_W.
- R2: Codes 4 and 5 add `src_a` to the immediate sign-extended from bit IMM_W-1, so a negative immediate subtracts.
- R3: `ovf` is 1 exactly when code 0, 2 or 4 overflows in two's complement. It is 0 for every other code, including the unsigned forms.
- R4: Codes 6 to 9 give the bitwise AND, OR, XOR and NOR of `src_a` and `src_b`.
- R5: Codes 10 to 12 combine `src_a` with the immediate zero-extended to DATA_W bits.
- R6: Code 13 puts the immediate in the top IMM_W bits of `result` and zeros in all lower bits.
- R7: Codes 16 and 17 write the upper half of the signed or unsigned 2*DATA_W-bit product to `hi_out` and the lower half to `lo_out`.
- R8: Codes 18 and 19 write the quotient, truncated toward zero, to `lo_out` and the remainder, which takes the sign of the dividend, to `hi_out`. The most negative dividend divided by -1 gives that same value as quotient and a remainder of 0.
- R9: Division by zero completes with normal timing. It leaves `lo_out` all ones and `hi_out` equal to the dividend.
- R10: Multiply or divide starts when the clock edge samples `op_valid` high, a code from 16 to 19 and `busy` low. `busy` is then high for DATA_W+1 cycles. `hilo_we` is high for exactly one cycle, the first one with `busy` low again, and `hi_out`/`lo_out` carry the new values in that cycle. They do not change in any other cycle.
- R11: A start request while `busy` is high is ignored. `op_valid` with codes 0 to 13 never starts the sequencer. For codes 16 to 19, `result` is 0 and `ovf` is 0.
- R12: After reset, `busy`, `hilo_we`, `hi_out` and `lo_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe for multiply and divide |
| op_code | input | 5 | Operation code (see R1) |
| src_a | input | DATA_W | First register operand; dividend or multiplicand |
| src_b | input | DATA_W | Second register operand; divisor or multiplier |
| imm | input | IMM_W | Immediate field |
| result | output | DATA_W | Combinational ALU result |
| ovf | output | 1 | Signed overflow flag |
| busy | output | 1 | Multiply/divide sequence in progress |
| hilo_we | output | 1 | One-cycle write strobe for HI/LO |
| hi_out | output | DATA_W | HI register value |
| lo_out | output | DATA_W | LO register value |

## Verification
The bench uses an 8-bit datapath with a 4-bit immediate. The register-form ALU codes are swept over every pair of operands. This covers every carry chain and every signed overflow boundary, and it tells the signed and unsigned add forms apart only through `ovf`. The immediate codes are swept over every operand and immediate value. This shows sign extension for add-immediate against zero extension for the logical forms, and the lower zero field of load-upper. Multiply and divide use a set of sixteen operands that includes 0, 1, -1, the most positive and most negative values and mixed patterns. These expose sign-fix errors, the quotient overflow case and the divide-by-zero values. A start request while busy, and ALU issue with the strobe high, show that the HI/LO contents and the timing are unaffected.

// File: rtl/iex_pkg.sv
package iex_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_ADDI  = 5'd4,
    OP_ADDIU = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOR   = 5'd9,
    OP_ANDI  = 5'd10,
    OP_ORI   = 5'd11,
    OP_XORI  = 5'd12,
    OP_LUI   = 5'd13,
    OP_MULT  = 5'd16,
    OP_MULTU = 5'd17,
    OP_DIV   = 5'd18,
    OP_DIVU  = 5'd19
  } iex_op_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR,
    LF_NOR
  } logic_fn_e;

  typedef enum logic [1:0] {
    RS_ARITH,
    RS_LOGIC,
    RS_UPPER,
    RS_NONE
  } res_sel_e;

  typedef enum logic [1:0] {
    MD_IDLE,
    MD_RUN,
    MD_FIX
  } md_state_e;

  typedef struct packed {
    res_sel_e  sel;
    logic      use_imm;
    logic      sext_imm;
    logic      sub;
    logic      chk_ovf;
    logic_fn_e lfn;
    logic      md_op;
    logic      md_div;
    logic      md_signed;
  } iex_dec_t;

endpackage

// File: rtl/iex_decode.sv
module iex_decode
  import iex_pkg::*;
(
  input  logic [4:0] op_code,
  output iex_dec_t   dec
);

  always_comb begin
    dec = '{sel: RS_NONE, use_imm: 1'b0, sext_imm: 1'b0, sub: 1'b0,
            chk_ovf: 1'b0, lfn: LF_AND, md_op: 1'b0, md_div: 1'b0,
            md_signed: 1'b0};
    case (op_code)
      OP_ADD:   begin dec.sel = RS_ARITH; dec.chk_ovf = 1'b1; end
      OP_ADDU:  begin dec.sel = RS_ARITH; end
      OP_SUB:   begin dec.sel = RS_ARITH; dec.sub = 1'b1; dec.chk_ovf = 1'b1; end
      OP_SUBU:  begin dec.sel = RS_ARITH; dec.sub = 1'b1; end
      OP_ADDI:  begin
        dec.sel = RS_ARITH; dec.use_imm = 1'b1; dec.sext_imm = 1'b1;
        dec.chk_ovf = 1'b1;
      end
      OP_ADDIU: begin dec.sel = RS_ARITH; dec.use_imm = 1'b1; dec.sext_imm = 1'b1; end
      OP_AND:   begin dec.sel = RS_LOGIC; dec.lfn = LF_AND; end
      OP_OR:    begin dec.sel = RS_LOGIC; dec.lfn = LF_OR; end
      OP_XOR:   begin dec.sel = RS_LOGIC; dec.lfn = LF_XOR; end
      OP_NOR:   begin dec.sel = RS_LOGIC; dec.lfn = LF_NOR; end
      OP_ANDI:  begin dec.sel = RS_LOGIC; dec.lfn = LF_AND; dec.use_imm = 1'b1; end
      OP_ORI:   begin dec.sel = RS_LOGIC; dec.lfn = LF_OR;  dec.use_imm = 1'b1; end
      OP_XORI:  begin dec.sel = RS_LOGIC; dec.lfn = LF_XOR; dec.use_imm = 1'b1; end
      OP_LUI:   begin dec.sel = RS_UPPER; end
      OP_MULT:  begin dec.md_op = 1'b1; dec.md_signed = 1'b1; end
      OP_MULTU: begin dec.md_op = 1'b1; end
      OP_DIV:   begin dec.md_op = 1'b1; dec.md_div = 1'b1; dec.md_signed = 1'b1; end
      OP_DIVU:  begin dec.md_op = 1'b1; dec.md_div = 1'b1; end
      default:  begin dec.sel = RS_NONE; end
    endcase
  end

endmodule

// File: rtl/iex_addsub.sv
module iex_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  input  logic         chk_ovf,
  output logic [W-1:0] sum,
  output logic         ovf
);

  localparam int unsigned MSB = W - 1;

  logic [W-1:0] opb_eff;
  logic [W-1:0] cin_vec;

  always_comb begin
    opb_eff = sub ? ~opb : opb;
    cin_vec = {{(W-1){1'b0}}, sub};
    sum     = opa + opb_eff + cin_vec;
    ovf     = chk_ovf & (opa[MSB] == opb_eff[MSB]) & (sum[MSB] != opa[MSB]);
  end

endmodule

// File: rtl/iex_logic.sv
module iex_logic
  import iex_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic_fn_e    fn,
  output logic [W-1:0] res
);

  always_comb begin
    case (fn)
      LF_AND:  res = opa & opb;
      LF_OR:   res = opa | opb;
      LF_XOR:  res = opa ^ opb;
      default: res = ~(opa | opb);
    endcase
  end

endmodule

// File: rtl/iex_muldiv.sv
module iex_muldiv
  import iex_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         div_op,
  input  logic         sgn_op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         hilo_we,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);

  localparam int unsigned MSB   = W - 1;
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  md_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     acc_q, acc_d;
  logic [W-1:0]     shf_q, shf_d;
  logic [W-1:0]     opnd_q, opnd_d;
  logic             div_q, div_d;
  logic             negq_q, negq_d;
  logic             negr_q, negr_d;
  logic             dz_q, dz_d;
  logic             we_q, we_d;
  logic [W-1:0]     hi_q, hi_d;
  logic [W-1:0]     lo_q, lo_d;
  logic             hilo_en;
  logic             work_en;

  logic [W-1:0]     mag_a, mag_b;
  logic [W:0]       mul_sum;
  logic [W:0]       div_trial;
  logic             div_take;
  logic [2*W-1:0]   prod_mag, prod_fin;
  logic [W-1:0]     quo_fin, rem_fin;

  // operand magnitudes for the signed forms
  always_comb begin
    mag_a = (sgn_op && opa[MSB]) ? (~opa + 1'b1) : opa;
    mag_b = (sgn_op && opb[MSB]) ? (~opb + 1'b1) : opb;
  end

  // one iteration step and final sign fix
  always_comb begin
    mul_sum   = {1'b0, acc_q} + (shf_q[0] ? {1'b0, opnd_q} : {(W+1){1'b0}});
    div_trial = {acc_q, shf_q[MSB]};
    div_take  = (div_trial >= {1'b0, opnd_q});
    prod_mag  = {acc_q, shf_q};
    prod_fin  = negq_q ? (~prod_mag + 1'b1) : prod_mag;
    quo_fin   = dz_q ? {W{1'b1}} : (negq_q ? (~shf_q + 1'b1) : shf_q);
    rem_fin   = negr_q ? (~acc_q + 1'b1) : acc_q;
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    shf_d   = shf_q;
    opnd_d  = opnd_q;
    div_d   = div_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    dz_d    = dz_q;
    we_d    = 1'b0;
    hi_d    = hi_q;
    lo_d    = lo_q;
    hilo_en = 1'b0;
    work_en = 1'b0;
    case (state_q)
      MD_IDLE: begin
        if (start) begin
          work_en = 1'b1;
          state_d = MD_RUN;
          cnt_d   = '0;
          acc_d   = '0;
          shf_d   = mag_a;
          opnd_d  = mag_b;
          div_d   = div_op;
          negq_d  = sgn_op & (opa[MSB] ^ opb[MSB]);
          negr_d  = sgn_op & div_op & opa[MSB];
          dz_d    = div_op & (opb == '0);
        end
      end
      MD_RUN: begin
        work_en = 1'b1;
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_d = MD_FIX;
        end
        if (div_q) begin
          acc_d = div_take ? (div_trial[W-1:0] - opnd_q) : div_trial[W-1:0];
          shf_d = {shf_q[W-2:0], div_take};
        end else begin
          acc_d = mul_sum[W:1];
          shf_d = {mul_sum[0], shf_q[W-1:1]};
        end
      end
      MD_FIX: begin
        state_d = MD_IDLE;
        we_d    = 1'b1;
        hilo_en = 1'b1;
        if (div_q) begin
          hi_d = rem_fin;
          lo_d = quo_fin;
        end else begin
          hi_d = prod_fin[2*W-1:W];
          lo_d = prod_fin[W-1:0];
        end
      end
      default: state_d = MD_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MD_IDLE;
      we_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= we_d;
      cnt_q   <= cnt_d;
    end
  end

  // datapath registers, enabled only while working
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      shf_q  <= '0;
      opnd_q <= '0;
      div_q  <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (work_en) begin
      acc_q  <= acc_d;
      shf_q  <= shf_d;
      opnd_q <= opnd_d;
      div_q  <= div_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
      dz_q   <= dz_d;
    end
  end

  // HI/LO storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (hilo_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign busy    = (state_q != MD_IDLE);
  assign hilo_we = we_q;
  assign hi      = hi_q;
  assign lo      = lo_q;

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              busy,
  output logic              hilo_we,
  output logic [DATA_W-1:0] hi_out,
  output logic [DATA_W-1:0] lo_out
);

  localparam int unsigned PAD = DATA_W - IMM_W;

  iex_dec_t          dec;
  logic [DATA_W-1:0] imm_sx, imm_zx, imm_up;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] arith_res, logic_res;
  logic              arith_ovf;
  logic              md_start;

  iex_decode u_dec (
    .op_code (op_code),
    .dec     (dec)
  );

  always_comb begin
    imm_sx = {{PAD{imm[IMM_W-1]}}, imm};
    imm_zx = {{PAD{1'b0}}, imm};
    imm_up = {imm, {PAD{1'b0}}};
    opnd_b = dec.use_imm ? (dec.sext_imm ? imm_sx : imm_zx) : src_b;
  end

  iex_addsub #(.W(DATA_W)) u_addsub (
    .opa     (src_a),
    .opb     (opnd_b),
    .sub     (dec.sub),
    .chk_ovf (dec.chk_ovf),
    .sum     (arith_res),
    .ovf     (arith_ovf)
  );

  iex_logic #(.W(DATA_W)) u_logic (
    .opa (src_a),
    .opb (opnd_b),
    .fn  (dec.lfn),
    .res (logic_res)
  );

  always_comb begin
    case (dec.sel)
      RS_ARITH: result = arith_res;
      RS_LOGIC: result = logic_res;
      RS_UPPER: result = imm_up;
      default:  result = '0;
    endcase
    ovf = (dec.sel == RS_ARITH) & arith_ovf;
  end

  assign md_start = op_valid & dec.md_op;

  iex_muldiv #(.W(DATA_W)) u_muldiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (md_start),
    .div_op  (dec.md_div),
    .sgn_op  (dec.md_signed),
    .opa     (src_a),
    .opb     (src_b),
    .busy    (busy),
    .hilo_we (hilo_we),
    .hi      (hi_out),
    .lo      (lo_out)
  );

endmodule

// File: rtl/iex_checker.sv
module iex_checker
  import iex_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        op_code,
  input logic [DATA_W-1:0] result,
  input logic              ovf,
  input logic              busy,
  input logic              hilo_we,
  input logic [DATA_W-1:0] hi_out,
  input logic [DATA_W-1:0] lo_out
);

  localparam int unsigned PAD   = DATA_W - IMM_W;
  localparam int unsigned RUN_W = $clog2(DATA_W + 3);
  localparam logic [RUN_W-1:0] MAX_BUSY = RUN_W'(DATA_W + 1);

  logic [RUN_W-1:0] busy_run;
  logic             is_signed_arith;
  logic             is_md;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else begin
      busy_run <= busy ? (busy_run + 1'b1) : '0;
    end
  end

  always_comb begin
    is_signed_arith = (op_code == OP_ADD) || (op_code == OP_SUB) || (op_code == OP_ADDI);
    is_md = (op_code == OP_MULT) || (op_code == OP_MULTU) ||
            (op_code == OP_DIV)  || (op_code == OP_DIVU);
  end

  // R3: only signed add, sub and add-immediate may flag overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_signed_arith |-> !ovf);

  // R6: load-upper clears the lower field
  p_upper_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_LUI) |-> (result[PAD-1:0] == '0));

  // R11: multiply/divide codes produce no ALU result
  p_md_result_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_md |-> (result == '0) && !ovf);

  // R10: write strobe in the first cycle after busy
  p_we_at_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> hilo_we);

  // R10: write strobe only right after a busy cycle
  p_we_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hilo_we |-> !busy && $past(busy));

  // R10: strobe lasts one cycle
  p_we_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hilo_we |=> !hilo_we);

  // R10: HI/LO change only with the strobe
  p_hilo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hilo_we |-> $stable(hi_out) && $stable(lo_out));

  // R10: busy never exceeds DATA_W+1 consecutive cycles
  p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < MAX_BUSY));

endmodule

bind int_exec_unit iex_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_iex_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_code (op_code),
  .result  (result),
  .ovf     (ovf),
  .busy    (busy),
  .hilo_we (hilo_we),
  .hi_out  (hi_out),
  .lo_out  (lo_out)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
  import iex_pkg::*;

  localparam int TW = 8;
  localparam int TI = 4;

  logic          clk;
  logic          rst_n;
  logic          op_valid;
  logic [4:0]    op_code;
  logic [TW-1:0] src_a;
  logic [TW-1:0] src_b;
  logic [TI-1:0] imm;
  logic [TW-1:0] result;
  logic          ovf;
  logic          busy;
  logic          hilo_we;
  logic [TW-1:0] hi_out;
  logic [TW-1:0] lo_out;

  int n_checks;
  int n_fail;

  int_exec_unit #(.DATA_W(TW), .IMM_W(TI)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .src_a    (src_a),
    .src_b    (src_b),
    .imm      (imm),
    .result   (result),
    .ovf      (ovf),
    .busy     (busy),
    .hilo_we  (hilo_we),
    .hi_out   (hi_out),
    .lo_out   (lo_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk8(input bit ok, input string req, input logic [TW-1:0] act,
                      input logic [TW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input bit ok, input string req, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic void alu_model(input logic [4:0] op, input logic [TW-1:0] a,
                                    input logic [TW-1:0] b, input logic [TI-1:0] im,
                                    output logic [TW-1:0] r, output logic v);
    int sa, sb, si, s;
    logic [TW-1:0] se, ze;
    sa = int'($signed(a));
    sb = int'($signed(b));
    se = {{(TW-TI){im[TI-1]}}, im};
    ze = {{(TW-TI){1'b0}}, im};
    si = int'($signed(se));
    v  = 1'b0;
    s  = 0;
    case (op)
      OP_ADD:   begin r = a + b;  s = sa + sb; v = (s > 127) || (s < -128); end
      OP_ADDU:  r = a + b;
      OP_SUB:   begin r = a - b;  s = sa - sb; v = (s > 127) || (s < -128); end
      OP_SUBU:  r = a - b;
      OP_ADDI:  begin r = a + se; s = sa + si; v = (s > 127) || (s < -128); end
      OP_ADDIU: r = a + se;
      OP_AND:   r = a & b;
      OP_OR:    r = a | b;
      OP_XOR:   r = a ^ b;
      OP_NOR:   r = ~(a | b);
      OP_ANDI:  r = a & ze;
      OP_ORI:   r = a | ze;
      OP_XORI:  r = a ^ ze;
      OP_LUI:   r = {im, {(TW-TI){1'b0}}};
      default:  r = '0;
    endcase
  endfunction

  function automatic void md_model(input logic [4:0] op, input logic [TW-1:0] a,
                                   input logic [TW-1:0] b, output logic [TW-1:0] h,
                                   output logic [TW-1:0] l);
    int sa, sb, ua, ub;
    logic [31:0] t, u;
    sa = int'($signed(a));
    sb = int'($signed(b));
    ua = int'(a);
    ub = int'(b);
    t = '0;
    u = '0;
    case (op)
      OP_MULTU: t = 32'(ua * ub);
      OP_MULT:  t = 32'(sa * sb);
      OP_DIVU:  if (ub != 0) begin t = 32'(ua % ub); u = 32'(ua / ub); end
      OP_DIV:   if (sb != 0) begin t = 32'(sa % sb); u = 32'(sa / sb); end
      default:  t = '0;
    endcase
    if (op == OP_MULTU || op == OP_MULT) begin
      h = t[2*TW-1:TW];
      l = t[TW-1:0];
    end else if (b == '0) begin
      h = a;
      l = '1;
    end else begin
      h = t[TW-1:0];
      l = u[TW-1:0];
    end
  endfunction

  task automatic md_run(input logic [4:0] op, input logic [TW-1:0] a, input logic [TW-1:0] b,
                        input string req);
    logic [TW-1:0] eh, el;
    md_model(op, a, b, eh, el);
    @(negedge clk);
    op_code  = op;
    src_a    = a;
    src_b    = b;
    op_valid = 1'b1;
    #1;
    chk8(result == '0, "R11 md result", result, '0);
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = OP_ADD;
    chk1(busy == 1'b1, "R10 busy after issue", busy, 1'b1);
    for (int k = 0; k < TW; k++) begin
      @(negedge clk);
      chk1(busy == 1'b1 && hilo_we == 1'b0, "R10 busy window", busy, 1'b1);
    end
    @(negedge clk);
    chk1(busy == 1'b0, "R10 busy end", busy, 1'b0);
    chk1(hilo_we == 1'b1, "R10 write strobe", hilo_we, 1'b1);
    chk8(hi_out == eh, req, hi_out, eh);
    chk8(lo_out == el, req, lo_out, el);
    @(negedge clk);
    chk1(hilo_we == 1'b0, "R10 strobe one cycle", hilo_we, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [TW-1:0] md_vals [16];
    logic [4:0]    reg_ops [8];
    logic [4:0]    imm_ops [6];
    logic [4:0]    md_ops  [4];
    logic [TW-1:0] er, hold_hi, hold_lo;
    logic          ev;
    int            pulses;

    md_vals = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h07, 8'h7f, 8'h80,
                8'h81, 8'hfe, 8'hff, 8'h40, 8'h55, 8'haa, 8'h10, 8'h33};
    reg_ops = '{OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_AND, OP_OR, OP_XOR, OP_NOR};
    imm_ops = '{OP_ADDI, OP_ADDIU, OP_ANDI, OP_ORI, OP_XORI, OP_LUI};
    md_ops  = '{OP_MULT, OP_MULTU, OP_DIV, OP_DIVU};
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_code  = OP_ADD;
    src_a    = '0;
    src_b    = '0;
    imm      = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk1(busy == 1'b0, "R12 busy", busy, 1'b0);
    chk1(hilo_we == 1'b0, "R12 hilo_we", hilo_we, 1'b0);
    chk8(hi_out == '0, "R12 hi", hi_out, '0);
    chk8(lo_out == '0, "R12 lo", lo_out, '0);

    // R7 R8 R9: multiply and divide over a corner-rich operand set
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          if (md_ops[o] == OP_MULT || md_ops[o] == OP_MULTU)
            md_run(md_ops[o], md_vals[i], md_vals[j], "R7 product");
          else if (md_vals[j] == '0)
            md_run(md_ops[o], md_vals[i], md_vals[j], "R9 divide by zero");
          else
            md_run(md_ops[o], md_vals[i], md_vals[j], "R8 quotient/remainder");
        end
      end
    end

    // R11: second start while busy is ignored
    @(negedge clk);
    op_code  = OP_MULTU;
    src_a    = 8'd13;
    src_b    = 8'd11;
    op_valid = 1'b1;
    @(negedge clk);
    op_code  = OP_DIVU;
    src_a    = 8'd200;
    src_b    = 8'd3;
    pulses   = 0;
    for (int k = 0; k < 20; k++) begin
      if (k == 3) op_valid = 1'b0;
      @(negedge clk);
      if (hilo_we) begin
        pulses++;
        chk8(hi_out == 8'h00, "R11 ignored start hi", hi_out, 8'h00);
        chk8(lo_out == 8'h8f, "R11 ignored start lo", lo_out, 8'h8f);
      end
    end
    chk8(8'(pulses), "R11 single completion", 8'(pulses), 8'd1);
    chk8(pulses == 1 ? 8'd1 : 8'(pulses), "R11 single completion", 8'(pulses), 8'd1);
    chk1(busy == 1'b0, "R11 no restart", busy, 1'b0);

    hold_hi = hi_out;
    hold_lo = lo_out;

    // R1 R3 R4: register-form sweep, issue strobe held high
    op_valid = 1'b1;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int o = 0; o < 8; o++) begin
          op_code = reg_ops[o];
          src_a   = 8'(a);
          src_b   = 8'(b);
          #1;
          alu_model(reg_ops[o], 8'(a), 8'(b), imm, er, ev);
          if (o < 4) chk8(result == er, "R1 add/sub", result, er);
          else       chk8(result == er, "R4 logic", result, er);
          chk1(ovf == ev, "R3 overflow", ovf, ev);
        end
      end
    end

    // R2 R3 R5 R6: immediate-form sweep
    for (int a = 0; a < 256; a++) begin
      for (int m = 0; m < 16; m++) begin
        for (int o = 0; o < 6; o++) begin
          op_code = imm_ops[o];
          src_a   = 8'(a);
          src_b   = 8'(255 - a);
          imm     = 4'(m);
          #1;
          alu_model(imm_ops[o], 8'(a), 8'(255 - a), 4'(m), er, ev);
          if (o < 2)      chk8(result == er, "R2 add-immediate", result, er);
          else if (o < 5) chk8(result == er, "R5 logic-immediate", result, er);
          else            chk8(result == er, "R6 load-upper", result, er);
          chk1(ovf == ev, "R3 overflow imm", ovf, ev);
        end
      end
    end

    // R11 R10: ALU issue never starts the sequencer; HI/LO held
    @(negedge clk);
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk1(busy == 1'b0, "R11 alu issue no busy", busy, 1'b0);
    chk1(hilo_we == 1'b0, "R11 alu issue no write", hilo_we, 1'b0);
    chk8(hi_out == hold_hi, "R10 hi held", hi_out, hold_hi);
    chk8(lo_out == hold_lo, "R10 lo held", lo_out, hold_lo);

    summary();
    $finish;
  end

endmodule